// File: doc/BRIEF.md
# Shared Flash Owner Arbiter

This block decides which of three masters may drive a shared configuration flash: an on-board management controller, a host driver, or the power-on configuration loader. Ownership changes hands only through an idle state. A new owner is granted only after a programmable handover delay. The current owner is reported in an encoded field of a single control register, which software polls after it raises its request bit.

The management controller and the host both reach the flash through one memory-mapped control register. Each sets or clears its own request bit in that register, and the owner field in the same register is read-only. The loader asks for the flash through a dedicated input, which passes through one register stage. The loader holds the flash out of reset. The block also drives a registered one-hot select to the downstream flash data-path mux.

Top module: `flash_owner_arbiter`

## Requirements
- R1: Straight after reset the owner field (register bits 2:0) reads 4, the loader code, the one-hot select is 3'b100, and both request bits read 0.
- R2: The loader keeps ownership while `loader_active` is high. When `loader_active` is sampled low, the owner field reads 0 two clock edges later.
- R3: A register request from idle is granted exactly GRANT_LAT+1 clock edges after the write edge, and the owner field reads 0 in every cycle before that. The same latency applies to a loader request through `loader_active`.
- R4: When the owner's request is cleared, the owner field reads 0 after the next clock edge, a code other than the releasing owner's.
- R5: From idle, the priority order is loader (code 4), then controller (bit 4, code 1), then host (bit 5, code 2). When several requests are pending, the highest one is granted.
- R6: A current owner is never preempted. While its request stays set, new requests from other masters leave the owner field unchanged.
- R7: A handover between two owners shows code 0 for GRANT_LAT+1 cycles before the new owner's code appears.
- R8: A register write changes only bit 4 and bit 5. Writes to bits 2:0 and to any other bit are ignored, and those bits read back as zero apart from the owner code.
- R9: `flash_sel` is one-hot or zero. Bit 0 is the controller, bit 1 the host and bit 2 the loader. It is all zero exactly when the owner field reads 0.
- R10: If a request is withdrawn before its grant completes, the block returns to idle and grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loader_active | input | 1 | Configuration loader requests the flash |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data: bit 4 controller request, bit 5 host request |
| reg_rdata | output | DATA_W | Control register: bits 2:0 owner code, bits 4 and 5 request bits |
| flash_sel | output | 3 | Registered one-hot select to the flash data-path mux |

## Verification
The assertions assume that a master clears only its own request and that it keeps the request set for as long as it wants the flash. They also assume a synchronous reset held for at least one edge. The bench keeps to this. It drives every request change at the falling edge, and it begins each scenario from a confirmed idle owner. It changes `loader_active` only when the loader's behaviour is the thing under test. It runs all seven non-empty combinations of the three requests. The withdrawn-request case uses a GRANT_LAT of at least 2, so that the withdrawal lands inside the handover window.

// File: rtl/fmx_pkg.sv
package fmx_pkg;

  typedef enum logic [2:0] {
    OWN_NONE   = 3'd0,
    OWN_CTL    = 3'd1,
    OWN_HOST   = 3'd2,
    OWN_LOADER = 3'd4
  } owner_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } arb_st_e;

  localparam int CODE_W       = 3;
  localparam int CTL_REQ_BIT  = 4;
  localparam int HOST_REQ_BIT = 5;
  localparam int SEL_W        = 3;

  function automatic logic [SEL_W-1:0] owner_onehot(owner_e o);
    logic [SEL_W-1:0] s;
    case (o)
      OWN_CTL:    s = 3'b001;
      OWN_HOST:   s = 3'b010;
      OWN_LOADER: s = 3'b100;
      default:    s = 3'b000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fmx_req_regs.sv
module fmx_req_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              loader_in,
  output logic              ctl_req,
  output logic              host_req,
  output logic              loader_req
);
  import fmx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_req    <= 1'b0;
      host_req   <= 1'b0;
      loader_req <= 1'b1;
    end else begin
      loader_req <= loader_in;
      if (wr_en) begin
        ctl_req  <= wdata[CTL_REQ_BIT];
        host_req <= wdata[HOST_REQ_BIT];
      end
    end
  end

endmodule

// File: rtl/fmx_arb_fsm.sv
module fmx_arb_fsm #(
  parameter int GRANT_LAT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_req,
  input  logic            host_req,
  input  logic            loader_req,
  output fmx_pkg::owner_e owner_d,
  output fmx_pkg::owner_e owner_q
);
  import fmx_pkg::*;

  localparam int LAT_W = (GRANT_LAT < 2) ? 1 : $clog2(GRANT_LAT);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(GRANT_LAT - 1);

  arb_st_e          st_q, st_d;
  owner_e           tgt_q, tgt_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;

  function automatic logic req_of(owner_e o, logic c, logic h, logic l);
    case (o)
      OWN_CTL:    return c;
      OWN_HOST:   return h;
      OWN_LOADER: return l;
      default:    return 1'b0;
    endcase
  endfunction

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    owner_d = owner_q;
    case (st_q)
      ST_IDLE: begin
        if (loader_req || ctl_req || host_req) begin
          st_d  = ST_WAIT;
          cnt_d = LAT_LOAD;
          if (loader_req)   tgt_d = OWN_LOADER;
          else if (ctl_req) tgt_d = OWN_CTL;
          else              tgt_d = OWN_HOST;
        end
      end
      ST_WAIT: begin
        if (!req_of(tgt_q, ctl_req, host_req, loader_req)) begin
          st_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          st_d    = ST_OWN;
          owner_d = tgt_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (!req_of(owner_q, ctl_req, host_req, loader_req)) begin
          st_d    = ST_IDLE;
          owner_d = OWN_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OWN;
      tgt_q   <= OWN_LOADER;
      cnt_q   <= '0;
      owner_q <= OWN_LOADER;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
      owner_q <= owner_d;
    end
  end

  // R6: an owner whose request stays set keeps the flash
  a_r6_hold_ctl: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_CTL && ctl_req) |=> owner_q == OWN_CTL);
  a_r6_hold_host: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_HOST && host_req) |=> owner_q == OWN_HOST);
  // R2: the loader holds while its synchronised request is high
  a_r2_hold_loader: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_LOADER && loader_req) |=> owner_q == OWN_LOADER);
  // R4: a cleared request releases to idle on the next edge
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (owner_q != OWN_NONE && !req_of(owner_q, ctl_req, host_req, loader_req))
    |=> owner_q == OWN_NONE);
  // R7: no direct switch from one owner to another
  a_r7_via_idle: assert property (@(posedge clk) disable iff (rst)
    (owner_q != OWN_NONE) |=> (owner_q == OWN_NONE || owner_q == $past(owner_q)));
  // R7: leaving idle never grants on the very next edge
  a_r7_idle_then_wait: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |=> owner_q == OWN_NONE);

endmodule

// File: rtl/fmx_sel_out.sv
module fmx_sel_out (
  input  logic                   clk,
  input  logic                   rst,
  input  fmx_pkg::owner_e        owner_d,
  output logic [fmx_pkg::SEL_W-1:0] sel_q
);
  import fmx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= owner_onehot(OWN_LOADER);
    else     sel_q <= owner_onehot(owner_d);
  end

  // R9: at most one master is selected
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_q));

endmodule

// File: rtl/flash_owner_arbiter.sv
module flash_owner_arbiter #(
  parameter int DATA_W    = 32,
  parameter int GRANT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loader_active,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2:0]        flash_sel
);
  import fmx_pkg::*;

  logic   ctl_req, host_req, loader_req;
  owner_e owner_d, owner_q;

  fmx_req_regs #(.DATA_W(DATA_W)) u_req (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata),
    .loader_in  (loader_active),
    .ctl_req    (ctl_req),
    .host_req   (host_req),
    .loader_req (loader_req)
  );

  fmx_arb_fsm #(.GRANT_LAT(GRANT_LAT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ctl_req    (ctl_req),
    .host_req   (host_req),
    .loader_req (loader_req),
    .owner_d    (owner_d),
    .owner_q    (owner_q)
  );

  fmx_sel_out u_sel (
    .clk     (clk),
    .rst     (rst),
    .owner_d (owner_d),
    .sel_q   (flash_sel)
  );

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[CODE_W-1:0]   = owner_q;
    reg_rdata[CTL_REQ_BIT]  = ctl_req;
    reg_rdata[HOST_REQ_BIT] = host_req;
  end

  // R9: select is empty exactly when the owner field reads idle
  a_r9_sel_matches_code: assert property (@(posedge clk) disable iff (rst)
    (flash_sel == 3'b000) == (reg_rdata[CODE_W-1:0] == 3'd0));
  // R8: a write clearing both request bits leaves both request bits clear
  a_r8_req_from_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[CTL_REQ_BIT] == 1'b0 && reg_wdata[HOST_REQ_BIT] == 1'b0)
    |=> (reg_rdata[CTL_REQ_BIT] == 1'b0 && reg_rdata[HOST_REQ_BIT] == 1'b0));

endmodule

// File: tb/test_flash_owner_arbiter.sv
module test_flash_owner_arbiter;
  localparam int LAT    = 3;
  localparam int DATA_W = 32;
  localparam time TCLK  = 8ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loader_active = 1'b1;
  logic              reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [2:0]        flash_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  flash_owner_arbiter #(.DATA_W(DATA_W), .GRANT_LAT(LAT)) i_flash_owner_arbiter (
    .clk(clk), .rst(rst), .loader_active(loader_active), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_sel(flash_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] sel_of(input logic [2:0] c);
    return (c == 3'd1) ? 3'b001 : (c == 3'd2) ? 3'b010 : (c == 3'd4) ? 3'b100 : 3'b000;
  endfunction

  function automatic logic [2:0] code();
    return reg_rdata[2:0];
  endfunction

  // drive at falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [31:0] d, input logic ld);
    reg_wr = 1'b1; reg_wdata = d; loader_active = ld;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic poll(output int n);
    n = 0;
    while (code() == 3'd0 && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic to_idle();
    wr(32'h0, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 code", code(), 3'd4);
    chk("R1 sel", flash_sel, 3'b100);
    chk("R1 req bits", reg_rdata[5:4], 2'b00);
    @(negedge clk);
    chk("R2 loader holds", code(), 3'd4);
    loader_active = 1'b0;
    @(negedge clk);
    chk("R2 one edge after drop", code(), 3'd4);
    @(negedge clk);
    chk("R2 released", code(), 3'd0);
    chk("R9 idle sel", flash_sel, 3'b000);
    @(negedge clk);

    // R3 R5 R9 R4: sweep all request combinations from idle
    for (int c = 1; c < 8; c++) begin
      w = c[2] ? 3'd4 : c[0] ? 3'd1 : 3'd2;
      wr({26'b0, c[1], c[0], 4'b0}, c[2]);
      chk("R3 idle right after request", code(), 3'd0);
      poll(n);
      chk("R3 grant latency", n, LAT + 1);
      chk("R5 winner", code(), w);
      chk("R9 sel", flash_sel, sel_of(w));
      repeat (2) @(negedge clk);
      chk("R6 held", code(), w);
      wr(32'h0, 1'b0);
      chk("R4 still owner at write edge", code(), w);
      @(negedge clk);
      chk("R4 released", code(), 3'd0);
      chk("R9 sel after release", flash_sel, 3'b000);
      @(negedge clk);
    end

    // R6: host owns, others request, no preemption
    wr(32'h20, 1'b0);
    poll(n);
    chk("R6 host granted", code(), 3'd2);
    wr(32'h30, 1'b1);
    for (int k = 0; k < 3 * LAT; k++) begin
      chk("R6 host not preempted", code(), 3'd2);
      @(negedge clk);
    end
    // R7 R5: release host with controller and loader pending
    wr(32'h10, 1'b1);
    chk("R7 host at write edge", code(), 3'd2);
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      chk("R7 idle gap", code(), 3'd0);
    end
    @(negedge clk);
    chk("R7 R5 loader next", code(), 3'd4);
    to_idle();

    // R7: controller to host handover
    wr(32'h30, 1'b0);
    poll(n);
    chk("R5 controller over host", code(), 3'd1);
    wr(32'h20, 1'b0);
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      chk("R7 idle gap ctl->host", code(), 3'd0);
    end
    @(negedge clk);
    chk("R7 host next", code(), 3'd2);
    chk("R9 host sel", flash_sel, 3'b010);
    to_idle();

    // R10: withdraw during handover
    wr(32'h20, 1'b0);
    wr(32'h00, 1'b0);
    for (int k = 0; k < 2 * LAT + 2; k++) begin
      chk("R10 no grant after withdraw", code(), 3'd0);
      @(negedge clk);
    end

    // R8: stray bits ignored
    wr(32'hFFFF_FFCF, 1'b0);
    for (int k = 0; k < 2 * LAT + 2; k++) begin
      chk("R8 stray bits idle", reg_rdata, 32'h0);
      @(negedge clk);
    end
    wr(32'h20, 1'b0);
    poll(n);
    wr(32'h0000_0027, 1'b0);
    @(negedge clk);
    chk("R8 readback while host owns", reg_rdata, 32'h0000_0022);
    to_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule